// File: doc/BRIEF.md
# Floppy Controller Host Glue

This block is the thin layer between an 8-bit host I/O bus and a floppy disk controller core with up to four drives. It owns the control register that picks a drive, switches the spindle motors, and holds the controller core in reset. The same register carries one enable bit that opens or closes every handshake line between the core and the host DMA and interrupt logic. The block also decodes an eight-entry register window, keeps a data-rate register, and shows the selected drive's disk-change line to the host.

The host writes with single-cycle strobes on a 3-bit address. Read data is chosen from the address in the same cycle and appears on `bus_rdata` one clock later. The core's status byte and data port are not stored here. The window passes them through, and the block raises read and write strobes toward the core when the data offset is accessed. A rate write with its top bit set gives the core a reset pulse that clears itself, while the host-visible control register keeps its value.

Top module: `fdc_host_glue`

## Requirements
- R1: After reset the control register is 0x00 and the rate register is 0x02. The core reset output is high, all motor outputs are low, drive 0 is selected, and `bus_rdata` is 0x00.
- R2: A write to offset 2 loads the control register, which reads back at offset 2. The field positions are: bits 1:0 give the drive number, decoded one-hot on `drive_sel_o`; bit 2 is the run bit; bit 3 is the transfer enable; bits 7:4 are the motor enables for drives 0 to 3, active high.
- R3: While the run bit is 0, `core_reset_o` and `core_ready_o` are both high. While the run bit is 1 and no soft reset is in progress, `core_reset_o` is low and `core_ready_o` follows `drv_ready_i`.
- R4: While the transfer enable is 0, the following hold: `host_irq_o`, `host_drq_o`, `core_dack_o` and `core_tc_o` are low, and `dack_rdata_o` is 0xFF. While it is 1, each of these outputs follows its source.
- R5: An interrupt or DMA request that is already pending reaches the host in the first cycle after a control write that sets the transfer enable.
- R6: A pulse on `tc_i` is stored until a control write with the run bit set clears it. The stored value reaches `core_tc_o` only while transfers are enabled.
- R7: Reads return the following per offset: 0 and 1 give 0x00; 3 and 6 give 0xFF; 4 gives `core_status_i`; 5 gives `core_rdata_i`. An access to offset 5 raises `core_rd_o` or `core_wr_o` in the same cycle.
- R8: A write to offset 4 stores the written byte with bit 7 cleared. If bit 7 was set, the core reset and ready outputs are high for the SRST_LEN cycles after the write. The control register does not change.
- R9: A write to offset 7 stores only bits 1:0 into the rate register and clears its upper bits. The rate codes are 00 = 500 kbps, 01 = 300 kbps, 10 = 250 kbps and 11 = 1000 kbps.
- R10: A read at offset 7 returns the disk-change input of the selected drive in bit 7, with bits 6:0 all ones.
- R11: Writes to offsets 0, 1, 3 and 6 leave the control and rate registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register window offset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Read strobe, used only for the core data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| core_status_i | input | 8 | Core status byte |
| core_rdata_i | input | 8 | Core data port read value |
| core_wdata_o | output | 8 | Data toward the core data port |
| core_wr_o | output | 1 | Core data port write strobe |
| core_rd_o | output | 1 | Core data port read strobe |
| core_reset_o | output | 1 | Core reset, active high |
| core_ready_o | output | 1 | Ready input of the core |
| drv_ready_i | input | 1 | Ready from the selected drive |
| core_int_i | input | 1 | Interrupt from the core |
| core_drq_i | input | 1 | DMA request from the core |
| host_irq_o | output | 1 | Gated interrupt to the host |
| host_drq_o | output | 1 | Gated DMA request to the host |
| host_dack_i | input | 1 | DMA acknowledge from the host |
| core_dack_o | output | 1 | Gated acknowledge to the core |
| core_dma_rdata_i | input | 8 | Byte offered by the core on a DMA read |
| dack_rdata_o | output | 8 | DMA read byte seen by the host |
| tc_i | input | 1 | Terminal count from the host DMA |
| core_tc_o | output | 1 | Stored, gated terminal count to the core |
| drive_sel_o | output | NUM_DRIVES | One-hot drive select |
| motor_o | output | NUM_DRIVES | Motor enables, active high |
| dskchg_i | input | NUM_DRIVES | Disk-change line of each drive |
| rate_o | output | 8 | Data-rate register |

## Verification
The bench targets three cases:
- A request that is pending before the enable is set. It must appear in the first cycle after the control write. A design that only passed new edges through would leave a DMA waiting forever.
- The stored terminal count. It must survive a control write that leaves the run bit clear and be erased by one that sets it. If this is wrong, the next transfer is cut short, or a stale count is lost.
- Rate writes with bit 7 set and loads at offset 7. A design that stored bit 7, kept stale upper bits, or touched the control register during the soft reset pulse would fail here. Random traffic also writes to the unmapped offsets, which must not disturb either register.

// File: rtl/fdc_glue_pkg.sv
package fdc_glue_pkg;
   localparam int ADDR_W = 3;
   localparam int DATA_W = 8;

   typedef enum logic [ADDR_W-1:0] {
      WIN_ID0     = 3'd0,
      WIN_ID1     = 3'd1,
      WIN_CTRL    = 3'd2,
      WIN_GAP3    = 3'd3,
      WIN_STATRT  = 3'd4,
      WIN_DATA    = 3'd5,
      WIN_GAP6    = 3'd6,
      WIN_INCFG   = 3'd7
   } win_e;

   // control register field positions (decoded by the drive and gate logic)
   localparam int CTL_SEL_LO   = 0;
   localparam int CTL_RUN      = 2;
   localparam int CTL_XFER_EN  = 3;
   localparam int CTL_MOTOR_LO = 4;
   localparam int MAX_DRIVES   = 4;

   localparam int RATE_SRST_BIT = 7;
   localparam logic [DATA_W-1:0] ID_RDATA = 8'h00;
endpackage

// File: rtl/fdc_ctrl_reg.sv
module fdc_ctrl_reg
   import fdc_glue_pkg::*;
#(
   parameter int NUM_DRIVES = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_i,
   input  logic [DATA_W-1:0]     wdata_i,
   output logic [DATA_W-1:0]     ctrl_o,
   output logic [1:0]            sel_idx_o,
   output logic                  run_o,
   output logic                  xfer_en_o,
   output logic [NUM_DRIVES-1:0] drive_sel_o,
   output logic [NUM_DRIVES-1:0] motor_o
);
   logic [DATA_W-1:0] ctrl_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    ctrl_q <= '0;
      else if (wr_i) ctrl_q <= wdata_i;
   end

   assign ctrl_o    = ctrl_q;
   assign sel_idx_o = ctrl_q[CTL_SEL_LO +: 2];
   assign run_o     = ctrl_q[CTL_RUN];
   assign xfer_en_o = ctrl_q[CTL_XFER_EN];

   for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drive
      assign drive_sel_o[d] = (sel_idx_o == 2'(d));
      assign motor_o[d]     = ctrl_q[CTL_MOTOR_LO + d];
   end

   assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (ctrl_q == $past(wdata_i)));
   assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(drive_sel_o));
endmodule

// File: rtl/fdc_xfer_gate.sv
module fdc_xfer_gate
   import fdc_glue_pkg::*;
#(
   parameter logic [DATA_W-1:0] IDLE_DMA_DATA = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_en_i,
   input  logic              tc_clr_i,
   input  logic              tc_i,
   input  logic              core_int_i,
   input  logic              core_drq_i,
   input  logic              host_dack_i,
   input  logic [DATA_W-1:0] core_dma_rdata_i,
   output logic              host_irq_o,
   output logic              host_drq_o,
   output logic              core_dack_o,
   output logic              core_tc_o,
   output logic [DATA_W-1:0] dack_rdata_o
);
   logic tc_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        tc_q <= 1'b0;
      else if (tc_clr_i) tc_q <= 1'b0;
      else if (tc_i)     tc_q <= 1'b1;
   end

   // levels are re-evaluated continuously, so a pending line passes as soon as the enable opens
   assign host_irq_o   = core_int_i  & xfer_en_i;
   assign host_drq_o   = core_drq_i  & xfer_en_i;
   assign core_dack_o  = host_dack_i & xfer_en_i;
   assign core_tc_o    = tc_q        & xfer_en_i;
   assign dack_rdata_o = xfer_en_i ? core_dma_rdata_i : IDLE_DMA_DATA;

   assert_tc_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tc_clr_i |=> !tc_q);
   assert_tc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_q && !tc_clr_i) |=> tc_q);
endmodule

// File: rtl/fdc_rate_reg.sv
module fdc_rate_reg
   import fdc_glue_pkg::*;
#(
   parameter int                SRST_LEN  = 2,
   parameter logic [DATA_W-1:0] RATE_INIT = 8'h02
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              full_wr_i,
   input  logic              low_wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rate_o,
   output logic              srst_o
);
   localparam int CNT_W = $clog2(SRST_LEN + 1);

   logic [DATA_W-1:0] rate_q;
   logic [CNT_W-1:0]  srst_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rate_q   <= RATE_INIT;
         srst_cnt <= '0;
      end else begin
         if (srst_cnt != '0) srst_cnt <= srst_cnt - 1'b1;
         if (full_wr_i) begin
            rate_q <= {1'b0, wdata_i[DATA_W-2:0]};
            if (wdata_i[RATE_SRST_BIT]) srst_cnt <= CNT_W'(SRST_LEN);
         end else if (low_wr_i) begin
            rate_q <= {{(DATA_W-2){1'b0}}, wdata_i[1:0]};
         end
      end
   end

   assign rate_o = rate_q;
   assign srst_o = (srst_cnt != '0);

   assert_top_bit_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      full_wr_i |=> !rate_q[RATE_SRST_BIT]);
   assert_srst_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (full_wr_i && wdata_i[RATE_SRST_BIT]) |=> srst_o);
   assert_low_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (low_wr_i && !full_wr_i) |=> (rate_q[DATA_W-1:2] == '0));
endmodule

// File: rtl/fdc_host_glue.sv
module fdc_host_glue
   import fdc_glue_pkg::*;
#(
   parameter int                NUM_DRIVES    = 4,
   parameter int                SRST_LEN      = 2,
   parameter logic [DATA_W-1:0] RATE_INIT     = 8'h02,
   parameter logic [DATA_W-1:0] GAP_RDATA     = 8'hFF,
   parameter logic [DATA_W-1:0] IDLE_DMA_DATA = 8'hFF
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_wr,
   input  logic                  bus_rd,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   input  logic [DATA_W-1:0]     core_status_i,
   input  logic [DATA_W-1:0]     core_rdata_i,
   output logic [DATA_W-1:0]     core_wdata_o,
   output logic                  core_wr_o,
   output logic                  core_rd_o,
   output logic                  core_reset_o,
   output logic                  core_ready_o,
   input  logic                  drv_ready_i,
   input  logic                  core_int_i,
   input  logic                  core_drq_i,
   output logic                  host_irq_o,
   output logic                  host_drq_o,
   input  logic                  host_dack_i,
   output logic                  core_dack_o,
   input  logic [DATA_W-1:0]     core_dma_rdata_i,
   output logic [DATA_W-1:0]     dack_rdata_o,
   input  logic                  tc_i,
   output logic                  core_tc_o,
   output logic [NUM_DRIVES-1:0] drive_sel_o,
   output logic [NUM_DRIVES-1:0] motor_o,
   input  logic [NUM_DRIVES-1:0] dskchg_i,
   output logic [DATA_W-1:0]     rate_o
);
   if (NUM_DRIVES < 1 || NUM_DRIVES > MAX_DRIVES) begin : g_bad_drives
      $error("NUM_DRIVES must be 1..4");
   end
   if (SRST_LEN < 1) begin : g_bad_srst
      $error("SRST_LEN must be at least 1");
   end

   logic [DATA_W-1:0] ctrl;
   logic [1:0]        sel_idx;
   logic              run, xfer_en, srst;
   logic              ctrl_wr, rate_full_wr, rate_low_wr;
   logic [MAX_DRIVES-1:0] chg_pad;
   logic [DATA_W-1:0] rd_mux;

   assign ctrl_wr      = bus_wr && (bus_addr == WIN_CTRL);
   assign rate_full_wr = bus_wr && (bus_addr == WIN_STATRT);
   assign rate_low_wr  = bus_wr && (bus_addr == WIN_INCFG);

   fdc_ctrl_reg #(.NUM_DRIVES(NUM_DRIVES)) ctrl_i (
      .clk, .rst_n,
      .wr_i(ctrl_wr), .wdata_i(bus_wdata),
      .ctrl_o(ctrl), .sel_idx_o(sel_idx), .run_o(run), .xfer_en_o(xfer_en),
      .drive_sel_o(drive_sel_o), .motor_o(motor_o)
   );

   fdc_xfer_gate #(.IDLE_DMA_DATA(IDLE_DMA_DATA)) gate_i (
      .clk, .rst_n,
      .xfer_en_i(xfer_en),
      .tc_clr_i(ctrl_wr && bus_wdata[CTL_RUN]),
      .tc_i(tc_i), .core_int_i(core_int_i), .core_drq_i(core_drq_i),
      .host_dack_i(host_dack_i), .core_dma_rdata_i(core_dma_rdata_i),
      .host_irq_o(host_irq_o), .host_drq_o(host_drq_o),
      .core_dack_o(core_dack_o), .core_tc_o(core_tc_o),
      .dack_rdata_o(dack_rdata_o)
   );

   fdc_rate_reg #(.SRST_LEN(SRST_LEN), .RATE_INIT(RATE_INIT)) rate_i (
      .clk, .rst_n,
      .full_wr_i(rate_full_wr), .low_wr_i(rate_low_wr), .wdata_i(bus_wdata),
      .rate_o(rate_o), .srst_o(srst)
   );

   if (NUM_DRIVES == MAX_DRIVES) begin : g_chg_full
      assign chg_pad = dskchg_i;
   end else begin : g_chg_pad
      assign chg_pad = {{(MAX_DRIVES-NUM_DRIVES){1'b0}}, dskchg_i};
   end

   assign core_reset_o = !run || srst;
   assign core_ready_o = !run || srst || drv_ready_i;
   assign core_wdata_o = bus_wdata;
   assign core_wr_o    = bus_wr && (bus_addr == WIN_DATA);
   assign core_rd_o    = bus_rd && (bus_addr == WIN_DATA);

   always_comb begin
      unique case (win_e'(bus_addr))
         WIN_ID0, WIN_ID1: rd_mux = ID_RDATA;
         WIN_CTRL:         rd_mux = ctrl;
         WIN_STATRT:       rd_mux = core_status_i;
         WIN_DATA:         rd_mux = core_rdata_i;
         WIN_INCFG:        rd_mux = {chg_pad[sel_idx], 7'h7F};
         default:          rd_mux = GAP_RDATA;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) bus_rdata <= '0;
      else        bus_rdata <= rd_mux;
   end

   assert_reset_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
      core_reset_o |-> core_ready_o);
   assert_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl[CTL_XFER_EN] |-> (!host_irq_o && !host_drq_o && !core_tc_o && !core_dack_o));
   assert_gap_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (bus_addr == WIN_GAP3 || bus_addr == WIN_GAP6 || bus_addr == WIN_ID0
                  || bus_addr == WIN_ID1)) |=> ($stable(ctrl) && $stable(rate_o)));
   assert_srst_keeps_ctrl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rate_full_wr |=> $stable(ctrl));
endmodule

// File: tb/fdc_host_glue_tb.sv
module fdc_host_glue_tb_top;
   localparam int SRST = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] bus_addr = '0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0, bus_rdata;
   logic [7:0] core_status_i = '0, core_rdata_i = '0, core_wdata_o;
   logic core_wr_o, core_rd_o, core_reset_o, core_ready_o;
   logic drv_ready_i = 1'b0, core_int_i = 1'b0, core_drq_i = 1'b0;
   logic host_irq_o, host_drq_o, host_dack_i = 1'b0, core_dack_o;
   logic [7:0] core_dma_rdata_i = '0, dack_rdata_o;
   logic tc_i = 1'b0, core_tc_o;
   logic [3:0] drive_sel_o, motor_o, dskchg_i = '0;
   logic [7:0] rate_o;

   int n_chk = 0, n_fail = 0;
   bit rnd = 1'b1;
   bit live = 1'b0;

   // reference state
   logic [7:0] m_ctrl, m_rate, m_rd;
   bit m_tc;
   int m_cnt;

   always #5 clk = ~clk;

   fdc_host_glue #(.SRST_LEN(SRST)) dut_i (.*);

   function automatic logic [7:0] ref_read(input logic [2:0] a);
      case (a)
         3'd0, 3'd1: return 8'h00;
         3'd2:       return m_ctrl;
         3'd4:       return core_status_i;
         3'd5:       return core_rdata_i;
         3'd7:       return {dskchg_i[m_ctrl[1:0]], 7'h7F};
         default:    return 8'hFF;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctrl = 8'h00; m_rate = 8'h02; m_tc = 0; m_cnt = 0; m_rd = 8'h00;
      end else begin
         m_rd = ref_read(bus_addr);
         if (m_cnt > 0) m_cnt--;
         if (tc_i) m_tc = 1;
         if (bus_wr) begin
            case (bus_addr)
               3'd2: begin m_ctrl = bus_wdata; if (bus_wdata[2]) m_tc = 0; end
               3'd4: begin m_rate = bus_wdata & 8'h7F; if (bus_wdata[7]) m_cnt = SRST; end
               3'd7: m_rate = bus_wdata & 8'h03;
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      bit en, run;
      en = m_ctrl[3]; run = m_ctrl[2];
      chk("R2 drive_sel", drive_sel_o, 4'b1 << m_ctrl[1:0]);
      chk("R2 motor", motor_o, m_ctrl[7:4]);
      chk("R3 R8 core_reset", core_reset_o, !run || m_cnt > 0);
      chk("R3 R8 core_ready", core_ready_o, !run || m_cnt > 0 || drv_ready_i);
      chk("R4 R5 host_irq", host_irq_o, core_int_i & en);
      chk("R4 R5 host_drq", host_drq_o, core_drq_i & en);
      chk("R4 core_dack", core_dack_o, host_dack_i & en);
      chk("R4 dack_rdata", dack_rdata_o, en ? core_dma_rdata_i : 8'hFF);
      chk("R6 core_tc", core_tc_o, m_tc & en);
      chk("R7 R10 bus_rdata", bus_rdata, m_rd);
      chk("R8 R9 rate", rate_o, m_rate);
      chk("R7 core_wr", core_wr_o, bus_wr && bus_addr == 3'd5);
      chk("R7 core_rd", core_rd_o, bus_rd && bus_addr == 3'd5);
      chk("R7 core_wdata", core_wdata_o, bus_wdata);
   endtask

   task automatic step(input logic [2:0] a, input bit w, input bit r, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
      if (rnd) begin
         core_int_i = 1'($urandom); core_drq_i = 1'($urandom);
         host_dack_i = 1'($urandom); drv_ready_i = 1'($urandom);
         tc_i = ($urandom % 8) == 0; dskchg_i = 4'($urandom);
         core_status_i = 8'($urandom); core_rdata_i = 8'($urandom);
         core_dma_rdata_i = 8'($urandom);
      end
      #1;
      if (live) compare_all();
   endtask

   task automatic read_all();
      for (int k = 0; k < 8; k++) step(3'(k), 1'b0, 1'b1, 8'h00);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1 reset state at the ports
      chk("R1 rate", rate_o, 8'h02);
      chk("R1 core_reset", core_reset_o, 1'b1);
      chk("R1 motor", motor_o, 4'h0);
      chk("R1 drive_sel", drive_sel_o, 4'b0001);
      chk("R1 rdata", bus_rdata, 8'h00);
      live = 1'b1;

      step(3'd2, 1, 0, 8'h1C); read_all();
      step(3'd2, 1, 0, 8'h27); read_all();
      step(3'd2, 1, 0, 8'hF5); read_all();
      step(3'd2, 1, 0, 8'h4E); read_all();
      step(3'd2, 1, 0, 8'h8F); read_all();

      // R8 soft reset and R9 low load
      step(3'd4, 1, 0, 8'h01); step(3'd0, 0, 0, 0);
      step(3'd4, 1, 0, 8'h83); repeat (4) step(3'd2, 0, 1, 0);
      chk("R8 rate bit7 cleared", rate_o, 8'h03);
      step(3'd7, 1, 0, 8'hFE); step(3'd0, 0, 0, 0);
      chk("R9 low load", rate_o, 8'h02);
      step(3'd4, 1, 0, 8'hFF); repeat (3) step(3'd0, 0, 0, 0);

      // R11 writes to unmapped and id offsets
      step(3'd0, 1, 0, 8'hAA); step(3'd1, 1, 0, 8'hAA);
      step(3'd3, 1, 0, 8'hAA); step(3'd6, 1, 0, 8'hAA);
      step(3'd2, 0, 1, 0); step(3'd0, 0, 0, 0);
      chk("R11 ctrl unchanged", bus_rdata, 8'h8F);
      chk("R11 rate unchanged", rate_o, 8'h7F);

      rnd = 1'b0;
      core_int_i = 1; core_drq_i = 1; tc_i = 0; host_dack_i = 0;
      // R5: pending request passes once enabled
      step(3'd2, 1, 0, 8'h04); step(3'd0, 0, 0, 0);
      chk("R5 drq masked", host_drq_o, 1'b0);
      step(3'd2, 1, 0, 8'h0C); step(3'd0, 0, 0, 0);
      chk("R5 drq passed", host_drq_o, 1'b1);
      chk("R5 irq passed", host_irq_o, 1'b1);
      // R6: stored tc kept across a run=0 write, cleared by run=1 write
      step(3'd2, 1, 0, 8'h00); tc_i = 1; step(3'd0, 0, 0, 0);
      tc_i = 0; step(3'd2, 1, 0, 8'h08); step(3'd0, 0, 0, 0);
      chk("R6 tc held", core_tc_o, 1'b1);
      step(3'd2, 1, 0, 8'h0C); step(3'd0, 0, 0, 0);
      chk("R6 tc cleared", core_tc_o, 1'b0);
      // R10 disk change of selected drive
      dskchg_i = 4'b0100;
      step(3'd2, 1, 0, 8'h0E); step(3'd7, 0, 1, 0); step(3'd0, 0, 0, 0);
      chk("R10 dir chg", bus_rdata, 8'hFF);
      step(3'd2, 1, 0, 8'h0D); step(3'd7, 0, 1, 0); step(3'd0, 0, 0, 0);
      chk("R10 dir nochg", bus_rdata, 8'h7F);
      rnd = 1'b1;

      for (int i = 0; i < 400; i++)
         step(3'($urandom), ($urandom % 10) < 3, 1'($urandom), 8'($urandom));

      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule